// File: doc/BRIEF.md
# Transactional Cache Conflict Tracker

This block is a small direct-mapped data cache for one core that runs every access inside a hardware transaction with lazy versioning. Each line carries a read mark and a write mark that the current transaction sets. Stores stay inside the cache, so memory sees nothing until the transaction commits. The first store to a line records that line's index in an ordered store-address queue. Lines are one data word wide, and a store miss allocates the line without a refill.

Other cores publish their commits as line addresses on an inbound snoop. A snoop that matches a line this transaction has read aborts the transaction. The abort discards every written line, clears all marks and empties the queue in one cycle, and the core re-executes the transaction. A snoop that matches a clean, unwritten line only invalidates it.

To commit, the core pulses `tx_commit`. The block holds an arbitration request until it is granted, then drains the queue in order and broadcasts each written line with its data. It then clears its marks, pulses `commit_done` and drops the request. Memory refill uses a request/acknowledge handshake.

Top module: `txn_cache`

## Requirements
- R1: After reset, `core_ack`, `overflow`, `arb_req`, `commit_done`, `violation`, `bc_valid` and `mem_req` are all low.
- R2: A load that misses raises `mem_req` with the line address on `mem_addr` and completes with `core_ack` and the `mem_data` value once `mem_ack` arrives. A later load of the same line is answered from the cache with no new refill.
- R3: A store keeps its data in the cache, and a later load of that line returns it. No broadcast occurs before the transaction commits.
- R4: After `tx_commit`, `arb_req` stays high and nothing is broadcast until `arb_gnt` is seen.
- R5: Once granted, the written lines are broadcast one per cycle, in the order of each line's first store. Each line is sent once with its latest data, and `bc_addr` is the full line address.
- R6: The cycle after the queue is empty, `commit_done` pulses for one cycle and `arb_req` falls in that same cycle. All marks are cleared, so a later snoop of a line read before the commit raises no violation.
- R7: A snoop that matches a read-marked line, while the grant is not held, pulses `violation` one cycle later and drops `arb_req`. Every written line is invalidated, so its next load refills the committed memory value, and the matched line is invalidated as well.
- R8: A snoop that matches an unmarked valid line invalidates it without a violation. A snoop that matches a line that is written but not read changes neither that line nor the violation output.
- R9: While the block holds the commit grant, snoops are ignored and no violation is raised.
- R10: A store to a line that already carries a write mark does not take another queue entry.
- R11: A store to a line with no write mark while the queue is full, or a miss whose victim line carries a mark, raises `overflow` and withholds `core_ack` for as long as the request is held. `overflow` falls one cycle after the request is withdrawn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_req | input | 1 | Core access request, held until `core_ack` |
| core_we | input | 1 | 1 = store, 0 = load |
| core_addr | input | LINE_AW | Line address of the access |
| core_wdata | input | DATA_W | Store data |
| core_ack | output | 1 | One-cycle completion pulse |
| core_rdata | output | DATA_W | Load data, valid with `core_ack` |
| overflow | output | 1 | Tracking resources exhausted; core is stalled |
| tx_commit | input | 1 | Pulse to start committing the transaction |
| arb_req | output | 1 | Commit arbitration request; falling releases the grant |
| arb_gnt | input | 1 | Commit arbitration grant |
| commit_done | output | 1 | One-cycle pulse when the commit has finished |
| violation | output | 1 | One-cycle pulse when the transaction was aborted |
| bc_valid | output | 1 | Outbound commit broadcast valid |
| bc_addr | output | LINE_AW | Broadcast line address |
| bc_data | output | DATA_W | Broadcast line data |
| snoop_valid | input | 1 | Inbound commit address from another core |
| snoop_addr | input | LINE_AW | Inbound committed line address |
| mem_req | output | 1 | Refill request, held until `mem_ack` |
| mem_addr | output | LINE_AW | Refill line address |
| mem_ack | input | 1 | Refill data valid |
| mem_data | input | DATA_W | Refill data |

## Verification
A stale or lost mark becomes visible at the ports within a few cycles. A missing read mark lets a conflicting snoop pass with no `violation` one cycle later. A read mark that is never cleared raises a false violation after a commit. A write mark that survives an abort shows up as stale data on the next load instead of a refill. A wrong queue entry changes the order, count or data of the broadcasts while the grant is held. A queue entry pushed twice brings `overflow` early on the next new line.

// File: rtl/tc_pkg.sv
package tc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FILL,
    ST_ARB,
    ST_DRAIN
  } tc_state_t;
endpackage

// File: rtl/tc_saq.sv
// Ordered queue of written line indexes, drained only while committing.
module tc_saq #(
  parameter int W     = 4,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] push_val,
  input  logic         pop,
  input  logic         flush,
  output logic         full,
  output logic         empty,
  output logic [W-1:0] head
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  slot [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push && !full) slot[wp] <= push_val;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push && !full) wp <= step(wp);
      if (pop && !empty) rp <= step(rp);
      cnt <= cnt + CW'(push && !full) - CW'(pop && !empty);
    end
  end

  assign full  = (cnt == CW'(DEPTH));
  assign empty = (cnt == '0);
  assign head  = slot[rp];
endmodule

// File: rtl/tc_marks.sv
// Per-line valid, read-mark and write-mark bits with one-cycle bulk clears.
module tc_marks #(
  parameter int IDX_W = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  upd_en,
  input  logic [IDX_W-1:0]      upd_idx,
  input  logic                  upd_v,
  input  logic                  upd_r,
  input  logic                  upd_w,
  input  logic                  inv_en,
  input  logic [IDX_W-1:0]      inv_idx,
  input  logic                  abort_all,
  input  logic                  clear_all,
  output logic [(1<<IDX_W)-1:0] vld,
  output logic [(1<<IDX_W)-1:0] rmk,
  output logic [(1<<IDX_W)-1:0] wmk
);
  localparam int LINES = 1 << IDX_W;

  for (genvar i = 0; i < LINES; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) begin
        vld[i] <= 1'b0;
        rmk[i] <= 1'b0;
        wmk[i] <= 1'b0;
      end else begin
        if (abort_all) begin
          vld[i] <= vld[i] & ~wmk[i];
          rmk[i] <= 1'b0;
          wmk[i] <= 1'b0;
        end else if (clear_all) begin
          rmk[i] <= 1'b0;
          wmk[i] <= 1'b0;
        end
        if (upd_en && upd_idx == IDX_W'(i)) begin
          vld[i] <= upd_v;
          rmk[i] <= upd_r;
          wmk[i] <= upd_w;
        end
        if (inv_en && inv_idx == IDX_W'(i)) vld[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/txn_cache.sv
module txn_cache
  import tc_pkg::*;
#(
  parameter int LINE_AW   = 12,
  parameter int IDX_W     = 4,
  parameter int DATA_W    = 32,
  parameter int SAQ_DEPTH = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               core_req,
  input  logic               core_we,
  input  logic [LINE_AW-1:0] core_addr,
  input  logic [DATA_W-1:0]  core_wdata,
  output logic               core_ack,
  output logic [DATA_W-1:0]  core_rdata,
  output logic               overflow,
  input  logic               tx_commit,
  output logic               arb_req,
  input  logic               arb_gnt,
  output logic               commit_done,
  output logic               violation,
  output logic               bc_valid,
  output logic [LINE_AW-1:0] bc_addr,
  output logic [DATA_W-1:0]  bc_data,
  input  logic               snoop_valid,
  input  logic [LINE_AW-1:0] snoop_addr,
  output logic               mem_req,
  output logic [LINE_AW-1:0] mem_addr,
  input  logic               mem_ack,
  input  logic [DATA_W-1:0]  mem_data
);
  localparam int TAG_W = LINE_AW - IDX_W;
  localparam int LINES = 1 << IDX_W;

  tc_state_t state;
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];
  logic [LINES-1:0]  vld, rmk, wmk;
  logic              drop_q;

  // request and snoop decode
  logic [IDX_W-1:0] r_idx, s_idx, f_idx, q_head;
  logic [TAG_W-1:0] r_tag, s_tag;
  logic hit, granted, snoop_live, s_hit, abort_now, inv_en;
  logic core_go, ovf_now, ld_hit, st_do, ld_miss, push, q_full, q_empty;
  logic fill_done, fill_keep, drain_end, pop;

  assign r_idx = core_addr[IDX_W-1:0];
  assign r_tag = core_addr[LINE_AW-1:IDX_W];
  assign s_idx = snoop_addr[IDX_W-1:0];
  assign s_tag = snoop_addr[LINE_AW-1:IDX_W];
  assign f_idx = mem_addr[IDX_W-1:0];

  assign hit        = vld[r_idx] && (tag_q[r_idx] == r_tag);
  assign granted    = (state == ST_DRAIN) || (state == ST_ARB && arb_gnt);
  assign snoop_live = snoop_valid && !granted;
  assign s_hit      = snoop_live && vld[s_idx] && (tag_q[s_idx] == s_tag);
  assign abort_now  = s_hit && rmk[s_idx];
  assign inv_en     = s_hit && !wmk[s_idx];

  assign core_go = (state == ST_IDLE) && core_req && !core_ack && !snoop_valid && !tx_commit;
  assign ovf_now = core_go && ((!hit && vld[r_idx] && (rmk[r_idx] || wmk[r_idx])) ||
                               (core_we && !(hit && wmk[r_idx]) && q_full));
  assign ld_hit  = core_go && !core_we && hit;
  assign st_do   = core_go && core_we && !ovf_now;
  assign ld_miss = core_go && !core_we && !hit && !ovf_now;
  assign push    = st_do && !(hit && wmk[r_idx]);

  assign fill_done = (state == ST_FILL) && mem_ack;
  assign fill_keep = !drop_q && !abort_now;
  assign drain_end = (state == ST_DRAIN) && q_empty;
  assign pop       = (state == ST_DRAIN) && !q_empty;

  // single write port into the line arrays
  logic               upd_en, upd_r, upd_w;
  logic [IDX_W-1:0]   upd_idx;
  always_comb begin
    upd_en  = 1'b0;
    upd_idx = r_idx;
    upd_r   = 1'b0;
    upd_w   = 1'b0;
    if (fill_done) begin
      upd_en  = 1'b1;
      upd_idx = f_idx;
      upd_r   = fill_keep;
    end else if (ld_hit) begin
      upd_en = 1'b1;
      upd_r  = 1'b1;
      upd_w  = wmk[r_idx];
    end else if (st_do) begin
      upd_en = 1'b1;
      upd_r  = hit && rmk[r_idx];
      upd_w  = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_done) begin
      data_q[f_idx] <= mem_data;
      tag_q[f_idx]  <= mem_addr[LINE_AW-1:IDX_W];
    end else if (st_do) begin
      data_q[r_idx] <= core_wdata;
      tag_q[r_idx]  <= r_tag;
    end
  end

  tc_marks #(.IDX_W(IDX_W)) i_marks (
    .clk(clk), .rst(rst),
    .upd_en(upd_en), .upd_idx(upd_idx), .upd_v(1'b1), .upd_r(upd_r), .upd_w(upd_w),
    .inv_en(inv_en), .inv_idx(s_idx),
    .abort_all(abort_now), .clear_all(drain_end),
    .vld(vld), .rmk(rmk), .wmk(wmk)
  );

  tc_saq #(.W(IDX_W), .DEPTH(SAQ_DEPTH)) i_saq (
    .clk(clk), .rst(rst),
    .push(push), .push_val(r_idx), .pop(pop), .flush(abort_now || drain_end),
    .full(q_full), .empty(q_empty), .head(q_head)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      core_ack    <= 1'b0;
      core_rdata  <= '0;
      overflow    <= 1'b0;
      arb_req     <= 1'b0;
      commit_done <= 1'b0;
      violation   <= 1'b0;
      bc_valid    <= 1'b0;
      bc_addr     <= '0;
      bc_data     <= '0;
      mem_req     <= 1'b0;
      mem_addr    <= '0;
      drop_q      <= 1'b0;
    end else begin
      core_ack    <= 1'b0;
      commit_done <= 1'b0;
      violation   <= abort_now;
      bc_valid    <= 1'b0;
      overflow    <= ovf_now;
      if (abort_now) arb_req <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (!abort_now) begin
            if (tx_commit) begin
              state   <= ST_ARB;
              arb_req <= 1'b1;
            end else if (ld_hit) begin
              core_ack   <= 1'b1;
              core_rdata <= data_q[r_idx];
            end else if (st_do) begin
              core_ack <= 1'b1;
            end else if (ld_miss) begin
              state    <= ST_FILL;
              mem_req  <= 1'b1;
              mem_addr <= core_addr;
              drop_q   <= 1'b0;
            end
          end
        end
        ST_FILL: begin
          if (mem_ack) begin
            mem_req <= 1'b0;
            state   <= ST_IDLE;
            if (fill_keep) begin
              core_ack   <= 1'b1;
              core_rdata <= mem_data;
            end
          end else if (abort_now) begin
            drop_q <= 1'b1;
          end
        end
        ST_ARB: begin
          if (arb_gnt) state <= ST_DRAIN;
          else if (abort_now) state <= ST_IDLE;
        end
        ST_DRAIN: begin
          if (!q_empty) begin
            bc_valid <= wmk[q_head];
            bc_addr  <= {tag_q[q_head], q_head};
            bc_data  <= data_q[q_head];
          end else begin
            commit_done <= 1'b1;
            arb_req     <= 1'b0;
            state       <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/txn_cache_chk.sv
module txn_cache_chk (
  input logic clk,
  input logic rst,
  input logic arb_req,
  input logic arb_gnt,
  input logic bc_valid,
  input logic violation,
  input logic commit_done,
  input logic overflow,
  input logic core_ack,
  input logic mem_req
);
  // R4
  bc_granted_chk: assert property (@(posedge clk) disable iff (rst)
    bc_valid |-> (arb_req && $past(arb_gnt)));
  // R9
  gnt_no_violation_chk: assert property (@(posedge clk) disable iff (rst)
    $past(arb_req && arb_gnt) |-> !violation);
  // R6
  done_release_chk: assert property (@(posedge clk) disable iff (rst)
    commit_done |-> (!arb_req && $past(arb_req)));
  // R7
  abort_drops_req_chk: assert property (@(posedge clk) disable iff (rst)
    violation |-> (!arb_req && !commit_done));
  // R11
  ovf_stall_chk: assert property (@(posedge clk) disable iff (rst)
    overflow |-> !core_ack);
  // R2
  fill_outside_commit_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !arb_req);
endmodule

bind txn_cache txn_cache_chk i_chk (.*);

// File: tb/test_txn_cache.sv
module test_txn_cache;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0, rst = 1'b1;
  logic       core_req = 0, core_we = 0, tx_commit = 0, arb_gnt = 0;
  logic       snoop_valid = 0, mem_ack = 0;
  logic [5:0] core_addr = '0, snoop_addr = '0;
  logic [7:0] core_wdata = '0, mem_data = '0;
  logic       core_ack, overflow, arb_req, commit_done, violation, bc_valid, mem_req;
  logic [7:0] core_rdata, bc_data;
  logic [5:0] bc_addr, mem_addr;

  txn_cache #(.LINE_AW(6), .IDX_W(2), .DATA_W(8), .SAQ_DEPTH(2)) i_txn_cache (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, failures = 0;
  int fills = 0, bcs = 0, viols = 0, dones = 0;
  int bc_a [16];
  int bc_d [16];
  logic [7:0] mem_img [64];
  bit gnt_en = 1'b0;

  task automatic eq(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // memory, arbiter and monitors, all on the falling edge
  always @(negedge clk) begin
    if (mem_ack) mem_ack = 1'b0;
    else if (mem_req) begin
      mem_ack  = 1'b1;
      mem_data = mem_img[mem_addr];
      fills++;
    end
    arb_gnt = arb_req && gnt_en;
    if (bc_valid) begin
      if (bcs < 16) begin
        bc_a[bcs] = int'(bc_addr);
        bc_d[bcs] = int'(bc_data);
      end
      mem_img[bc_addr] = bc_data;
      bcs++;
    end
    if (violation) viols++;
    if (commit_done) dones++;
  end

  task automatic acc(input bit we, input int a, input int d,
                     output int rd, output bit ok, output bit ov);
    core_we = we; core_addr = a[5:0]; core_wdata = d[7:0]; core_req = 1'b1;
    ok = 0; ov = 0; rd = -1;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (overflow) ov = 1;
      if (core_ack) begin
        ok = 1;
        rd = int'(core_rdata);
        break;
      end
    end
    core_req = 1'b0;
  endtask

  task automatic snoop(input int a);
    snoop_valid = 1'b1; snoop_addr = a[5:0];
    @(negedge clk);
    snoop_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic commit(input bit mid, input int sa, output bit done);
    tx_commit = 1'b1;
    @(negedge clk);
    tx_commit = 1'b0;
    if (mid) begin
      @(negedge clk);
      snoop_valid = 1'b1; snoop_addr = sa[5:0];
      @(negedge clk);
      snoop_valid = 1'b0;
    end
    done = 0;
    for (int k = 0; k < 40; k++) begin
      if (commit_done) begin
        done = 1;
        break;
      end
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int rd, f0, b0, v0;
    bit ok, ov, dn;
    for (int i = 0; i < 64; i++) mem_img[i] = 8'((i * 5 + 1) & 255);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    eq("R1 outputs", int'({core_ack, overflow, arb_req, commit_done, violation, bc_valid, mem_req}), 0);

    // R2 miss then hit
    acc(0, 6'h05, 0, rd, ok, ov);
    eq("R2 miss data", rd, 26);
    eq("R2 one refill", fills, 1);
    acc(0, 6'h05, 0, rd, ok, ov);
    eq("R2 hit data", rd, 26);
    eq("R2 no refill on hit", fills, 1);

    // R10 repeated store keeps one queue entry; R3 data stays local
    acc(1, 6'h02, 8'hA1, rd, ok, ov);
    acc(1, 6'h02, 8'hA2, rd, ok, ov);
    acc(1, 6'h0B, 8'hB3, rd, ok, ov);
    eq("R10 second line accepted", int'(ok && !ov), 1);
    f0 = fills;
    acc(0, 6'h02, 0, rd, ok, ov);
    eq("R3 store readback", rd, 8'hA2);
    eq("R3 no refill", fills, f0);
    eq("R3 no broadcast before commit", bcs, 0);

    // R4 wait for grant
    tx_commit = 1'b1;
    @(negedge clk);
    tx_commit = 1'b0;
    repeat (5) @(negedge clk);
    eq("R4 request held", int'(arb_req), 1);
    eq("R4 nothing sent", bcs, 0);
    gnt_en = 1'b1;
    dn = 0;
    for (int k = 0; k < 40 && !dn; k++) begin
      @(negedge clk);
      if (commit_done) begin
        dn = 1;
        eq("R6 request dropped with done", int'(arb_req), 0);
      end
    end
    @(negedge clk);
    eq("R6 commit done", int'(dn), 1);
    eq("R5 broadcast count", bcs, 2);
    eq("R5 first addr", bc_a[0], 6'h02);
    eq("R5 first data", bc_d[0], 8'hA2);
    eq("R5 second addr", bc_a[1], 6'h0B);
    eq("R5 second data", bc_d[1], 8'hB3);

    // R6 marks cleared, R8 clean line invalidated
    v0 = viols; f0 = fills;
    snoop(6'h05);
    eq("R6 no violation after commit", viols, v0);
    acc(0, 6'h05, 0, rd, ok, ov);
    eq("R8 clean line refilled", fills, f0 + 1);

    // R7 violation on read line
    acc(1, 6'h0B, 8'hCC, rd, ok, ov);
    v0 = viols;
    snoop(6'h05);
    eq("R7 violation raised", viols, v0 + 1);
    f0 = fills;
    acc(0, 6'h0B, 0, rd, ok, ov);
    eq("R7 written line discarded", rd, 8'hB3);
    acc(0, 6'h05, 0, rd, ok, ov);
    eq("R7 matched line refilled", fills, f0 + 2);
    commit(0, 0, dn);
    eq("R6 empty commit completes", int'(dn), 1);

    // R8 written-only line keeps data
    acc(1, 6'h0E, 8'h77, rd, ok, ov);
    v0 = viols;
    snoop(6'h0E);
    eq("R8 no violation on written line", viols, v0);
    f0 = fills;
    acc(0, 6'h0E, 0, rd, ok, ov);
    eq("R8 written data kept", rd, 8'h77);
    eq("R8 no refill", fills, f0);

    // R11 queue full and marked victim
    acc(1, 6'h0F, 8'h3C, rd, ok, ov);
    acc(1, 6'h00, 8'h11, rd, ok, ov);
    eq("R11 full queue stalls", int'({ok, ov}), 1);
    @(negedge clk);
    eq("R11 overflow clears", int'(overflow), 0);
    acc(0, 6'h06, 0, rd, ok, ov);
    eq("R11 marked victim stalls", int'({ok, ov}), 1);
    @(negedge clk);

    // R9 snoop ignored while granted
    acc(0, 6'h05, 0, rd, ok, ov);
    v0 = viols; b0 = bcs;
    commit(1, 6'h05, dn);
    eq("R9 no violation under grant", viols, v0);
    eq("R9 commit completes", bcs - b0, 2);
    eq("R5 queue order", bc_a[b0 < 16 ? b0 : 0], 6'h0E);

    // R7 abort while still arbitrating
    acc(0, 6'h05, 0, rd, ok, ov);
    gnt_en = 1'b0;
    v0 = viols;
    tx_commit = 1'b1;
    @(negedge clk);
    tx_commit = 1'b0;
    repeat (2) @(negedge clk);
    snoop(6'h05);
    eq("R7 abort in arbitration", viols, v0 + 1);
    eq("R7 request dropped", int'(arb_req), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule